// File: doc/BRIEF.md
# Mesh Dimension-Order Route Unit

This block picks the output port for a packet header arriving at one switch of a two-dimensional mesh. It subtracts the switch's own coordinates from the header's destination coordinates to get signed x and y offsets. From those offsets it chooses one of five outputs: west, east, south, north or the local processor. The choice is registered. It stays on the output until the next header is accepted, so the crossbar and the allocation logic downstream can read it across several cycles.

Two routing policies are available, and a mode input selects between them. In dimension-order mode the x offset is reduced to zero before any y movement, so congestion plays no part. In west-first mode any westward travel must still happen first. Once x is non-negative, the unit may choose freely between the productive east, north and south ports. When both an x and a y port are productive, it uses per-port congestion flags to decide. The x port wins unless only the x port is congested. Because no route turns into the west direction, the adaptive mode remains deadlock free. A build parameter can remove the adaptive logic altogether.

Top module: `mdor_route_unit`

## Requirements
- R1: When the destination x is less than the switch x, the selected port is west (port_sel bit 0) in both modes.
- R2: In dimension-order mode (mode=0), a destination x greater than the switch x selects east (bit 1), whatever the y offset.
- R3: In dimension-order mode with equal x, a smaller destination y selects south (bit 2) and a larger destination y selects north (bit 3).
- R4: When both coordinates match, the local port (bit 4) is selected in both modes.
- R5: In west-first mode (mode=1) with only one productive non-west direction, that direction is selected regardless of congestion.
- R6: In west-first mode with both an x and a y offset productive (x offset positive, y offset non-zero), the y port is selected only when the east congestion flag (cong bit 1) is set and the flag of the productive y port (bit 2 south, bit 3 north) is clear; otherwise east is selected.
- R7: The west port is never selected when the destination x is greater than or equal to the switch x.
- R8: port_sel updates on the rising clock edge at which hdr_valid is high and holds its value while hdr_valid is low.
- R9: After reset port_sel is all zeros; after any accepted header it has exactly one bit set (bit order: 0 west, 1 east, 2 south, 3 north, 4 local).
- R10: In dimension-order mode the congestion flags have no effect on the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header present; its route is captured on this edge |
| mode | input | 1 | 0 dimension-order, 1 west-first adaptive |
| my_x | input | X_W | This switch's x coordinate |
| my_y | input | Y_W | This switch's y coordinate |
| dst_x | input | X_W | Destination x coordinate from the header |
| dst_y | input | Y_W | Destination y coordinate from the header |
| cong | input | 4 | Congestion flags: bit 0 west, 1 east, 2 south, 3 north |
| port_sel | output | 5 | Registered one-hot output port |

## Verification
The bench drives coordinates at the edges of the range (0 against the maximum and the reverse). A unit that took the offset without its extra sign bit would then route a large positive difference west. It steers every adaptive case with both an x and a y port productive through all congestion patterns. A wrong tie-break would take the y port when both or neither flags are set, and a reversed test would flee from an uncongested east. Repeating the same header in dimension-order mode with the flags flipped exposes a design that lets congestion leak into the deterministic policy. Idle cycles with changing inputs catch an output register that is not gated by hdr_valid.

// File: rtl/mdor_pkg.sv
package mdor_pkg;
   localparam int unsigned NPORT = 5;
   localparam int unsigned P_WEST  = 0;
   localparam int unsigned P_EAST  = 1;
   localparam int unsigned P_SOUTH = 2;
   localparam int unsigned P_NORTH = 3;
   localparam int unsigned P_LOCAL = 4;
   typedef logic [NPORT-1:0] port_vec_t;

   typedef struct packed {
      logic x_neg;
      logic x_pos;
      logic y_neg;
      logic y_pos;
   } offs_sign_t;
endpackage

// File: rtl/mdor_offset.sv
module mdor_offset #(
   parameter int unsigned X_W = 4,
   parameter int unsigned Y_W = 4
) (
   input  logic [X_W-1:0]          my_x,
   input  logic [Y_W-1:0]          my_y,
   input  logic [X_W-1:0]          dst_x,
   input  logic [Y_W-1:0]          dst_y,
   output mdor_pkg::offs_sign_t    sgn
);
   localparam int unsigned DXW = X_W + 1;
   localparam int unsigned DYW = Y_W + 1;

   logic signed [DXW-1:0] dx;
   logic signed [DYW-1:0] dy;

   always_comb begin
      dx = $signed({1'b0, dst_x}) - $signed({1'b0, my_x});
      dy = $signed({1'b0, dst_y}) - $signed({1'b0, my_y});
      sgn.x_neg = dx[DXW-1];
      sgn.x_pos = !dx[DXW-1] && (dx != '0);
      sgn.y_neg = dy[DYW-1];
      sgn.y_pos = !dy[DYW-1] && (dy != '0);
   end
endmodule

// File: rtl/mdor_select.sv
module mdor_select #(
   parameter bit ADAPT_EN = 1'b1
) (
   input  mdor_pkg::offs_sign_t sgn,
   input  logic                 mode,
   input  logic [3:0]           cong,
   output mdor_pkg::port_vec_t  port
);
   import mdor_pkg::*;

   port_vec_t det_port;

   always_comb begin
      det_port = '0;
      if (sgn.x_neg)      det_port[P_WEST]  = 1'b1;
      else if (sgn.x_pos) det_port[P_EAST]  = 1'b1;
      else if (sgn.y_neg) det_port[P_SOUTH] = 1'b1;
      else if (sgn.y_pos) det_port[P_NORTH] = 1'b1;
      else                det_port[P_LOCAL] = 1'b1;
   end

   generate
      if (ADAPT_EN) begin : g_adapt
         port_vec_t wf_port;
         logic      y_busy;
         always_comb begin
            wf_port = '0;
            y_busy  = sgn.y_neg ? cong[P_SOUTH] : cong[P_NORTH];
            if (sgn.x_neg) begin
               wf_port[P_WEST] = 1'b1;
            end else if (sgn.x_pos && (sgn.y_neg || sgn.y_pos)) begin
               if (cong[P_EAST] && !y_busy) begin
                  if (sgn.y_neg) wf_port[P_SOUTH] = 1'b1;
                  else           wf_port[P_NORTH] = 1'b1;
               end else begin
                  wf_port[P_EAST] = 1'b1;
               end
            end else begin
               wf_port = det_port;
            end
         end
         assign port = mode ? wf_port : det_port;
      end else begin : g_fixed
         logic unused_adapt;
         assign unused_adapt = ^{mode, cong};
         assign port = det_port;
      end
   endgenerate
endmodule

// File: rtl/mdor_route_unit.sv
module mdor_route_unit #(
   parameter int unsigned X_W      = 4,
   parameter int unsigned Y_W      = 4,
   parameter bit          ADAPT_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hdr_valid,
   input  logic           mode,
   input  logic [X_W-1:0] my_x,
   input  logic [Y_W-1:0] my_y,
   input  logic [X_W-1:0] dst_x,
   input  logic [Y_W-1:0] dst_y,
   input  logic [3:0]     cong,
   output logic [4:0]     port_sel
);
   import mdor_pkg::*;

   initial begin
      assert (X_W >= 1 && X_W <= 16) else $error("X_W out of range");
      assert (Y_W >= 1 && Y_W <= 16) else $error("Y_W out of range");
   end

   offs_sign_t sgn;
   port_vec_t  next_port;
   port_vec_t  port_q;

   mdor_offset #(.X_W(X_W), .Y_W(Y_W)) u_offset (
      .my_x(my_x), .my_y(my_y), .dst_x(dst_x), .dst_y(dst_y), .sgn(sgn)
   );

   mdor_select #(.ADAPT_EN(ADAPT_EN)) u_select (
      .sgn(sgn), .mode(mode), .cong(cong), .port(next_port)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         port_q <= '0;
      else if (hdr_valid) port_q <= next_port;
   end

   assign port_sel = port_q;
endmodule

// File: rtl/mdor_route_unit_chk.sv
module mdor_route_unit_chk #(
   parameter int unsigned X_W = 4,
   parameter int unsigned Y_W = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           hdr_valid,
   input logic           mode,
   input logic [X_W-1:0] my_x,
   input logic [Y_W-1:0] my_y,
   input logic [X_W-1:0] dst_x,
   input logic [Y_W-1:0] dst_y,
   input logic [3:0]     cong,
   input logic [4:0]     port_sel
);
   AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(port_sel)); // R9
   AST_ACCEPT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> $onehot(port_sel)); // R9
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_valid |=> $stable(port_sel)); // R8
   AST_WEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && dst_x < my_x) |=> port_sel == 5'b00001); // R1
   AST_NO_WEST_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && dst_x >= my_x) |=> !port_sel[0]); // R7
   AST_LOCAL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && dst_x == my_x && dst_y == my_y) |=> port_sel == 5'b10000); // R4
   AST_DOR_EAST: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && !mode && dst_x > my_x) |=> port_sel == 5'b00010); // R2
endmodule

bind mdor_route_unit mdor_route_unit_chk #(.X_W(X_W), .Y_W(Y_W)) u_chk (.*);

// File: tb/mdor_route_unit_bench.sv
module mdor_route_unit_bench;
   localparam int XW = 4;
   localparam int YW = 4;
   localparam int XMAX = (1 << XW) - 1;
   localparam int YMAX = (1 << YW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hdr_valid = 1'b0;
   logic mode = 1'b0;
   logic [XW-1:0] my_x = '0, dst_x = '0;
   logic [YW-1:0] my_y = '0, dst_y = '0;
   logic [3:0] cong = '0;
   logic [4:0] port_sel;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mdor_route_unit #(.X_W(XW), .Y_W(YW)) u_mdor_route_unit (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .mode(mode),
      .my_x(my_x), .my_y(my_y), .dst_x(dst_x), .dst_y(dst_y),
      .cong(cong), .port_sel(port_sel));

   function automatic logic [4:0] model(int dx, int dy, bit m, logic [3:0] c);
      int yi;
      if (dx < 0) return 5'b00001;
      if (dx == 0 && dy == 0) return 5'b10000;
      if (!m) begin
         if (dx > 0) return 5'b00010;
         return (dy < 0) ? 5'b00100 : 5'b01000;
      end
      if (dx > 0 && dy != 0) begin
         yi = (dy < 0) ? 2 : 3;
         if (c[1] && !c[yi]) return (dy < 0) ? 5'b00100 : 5'b01000;
         return 5'b00010;
      end
      if (dx > 0) return 5'b00010;
      return (dy < 0) ? 5'b00100 : 5'b01000;
   endfunction

   function automatic string tag_of(int dx, int dy, bit m);
      if (dx < 0) return "R1";
      if (dx == 0 && dy == 0) return "R4";
      if (!m) return (dx > 0) ? "R2" : "R3";
      return (dx > 0 && dy != 0) ? "R6" : "R5";
   endfunction

   task automatic check(logic [4:0] got, logic [4:0] exp, string tag);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: port_sel=%b expected=%b", tag, got, exp);
      end
   endtask

   task automatic route(int mx, int my, int tx, int ty, bit m, logic [3:0] c);
      logic [4:0] exp;
      int dx, dy;
      my_x = mx[XW-1:0]; my_y = my[YW-1:0];
      dst_x = tx[XW-1:0]; dst_y = ty[YW-1:0];
      mode = m; cong = c; hdr_valid = 1'b1;
      dx = tx - mx; dy = ty - my;
      exp = model(dx, dy, m, c);
      @(negedge clk);
      hdr_valid = 1'b0;
      check(port_sel, exp, tag_of(dx, dy, m));
      if (dx >= 0) check({4'b0, port_sel[0]}, 5'b0, "R7");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: expired actual=1 expected=0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [4:0] held;
      void'($urandom(32'h1BAD5EED));
      repeat (3) @(negedge clk);
      check(port_sel, 5'b00000, "R9");
      rst_n = 1'b1;
      @(negedge clk);
      check(port_sel, 5'b00000, "R9");

      // directed corners
      route(XMAX, 3, 0, 3, 0, 4'h0);          // R1 far west
      route(XMAX, 3, 0, 9, 1, 4'hF);          // R1 west-first, adaptive mode
      route(0, YMAX, XMAX, 0, 0, 4'h0);       // R2 range edge
      route(5, 5, 5, 0, 0, 4'h0);             // R3 south
      route(5, 0, 5, YMAX, 0, 4'h0);          // R3 north
      route(7, 7, 7, 7, 0, 4'h0);             // R4
      route(7, 7, 7, 7, 1, 4'hF);             // R4 adaptive
      route(2, 2, 9, 2, 1, 4'hF);             // R5 east only, congested
      route(2, 9, 2, 1, 1, 4'hF);             // R5 south only
      for (int c = 0; c < 16; c++) begin      // R6 all congestion patterns
         route(1, 4, 6, 10, 1, c[3:0]);
         route(1, 10, 6, 4, 1, c[3:0]);
      end
      // R10: same header, flags flipped, dimension order
      route(1, 1, 8, 12, 0, 4'b0010);
      check(port_sel, 5'b00010, "R10");
      route(1, 1, 8, 12, 0, 4'b1101);
      check(port_sel, 5'b00010, "R10");

      // R8: hold while idle with changing inputs
      route(3, 3, 10, 3, 0, 4'h0);
      held = port_sel;
      for (int i = 0; i < 6; i++) begin
         dst_x = $urandom; dst_y = $urandom; mode = $urandom; cong = $urandom;
         @(negedge clk);
         check(port_sel, held, "R8");
      end

      // constrained random
      for (int i = 0; i < 400; i++) begin
         route($urandom_range(0, XMAX), $urandom_range(0, YMAX),
               $urandom_range(0, XMAX), $urandom_range(0, YMAX),
               1'($urandom), 4'($urandom));
         if (!$onehot(port_sel)) check(port_sel, 5'b00001, "R9");
         if (($urandom & 3) == 0) @(negedge clk);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule